// File: doc/BRIEF.md
# Ping-Pong DMA Descriptor Bank

This block keeps, for each of seven DMA channels, two complete transfer descriptors. Each descriptor holds a buffer address, a byte length and a command word. One descriptor of a channel is live and drives word requests toward memory. Software meanwhile fills in the other one. Once the live descriptor has drained, software asks the channel to swap roles. The freshly written descriptor then takes over, and the old one becomes free to program again.

Software reaches everything through one 32-bit register port with a write strobe and a combinational read. Each channel has its own control word, its own memory request/acknowledge pair and its own interrupt line. A live descriptor moves one word per acknowledge. When its length runs out, the descriptor disarms itself and raises a sticky completion flag.

Top module: `dbd_dma_bank`

## Requirements
- R1: Register map. The control word of channel c is at 0xC00 + 16·c. The descriptors of channel c start at 0x1000 + 32·c. Set s adds 16·s. Within a set, the address is at +0, the length at +4 and the command at +8. Any other offset reads as zero.
- R2: After reset, every register reads zero, set 0 is live, and all request and interrupt outputs are low.
- R3: A length write keeps only bits [15:2], so the value is word-aligned. Bits 1:0 and the bits above 15 read back as zero.
- R4: Command bit 0 arms a set. While the live set is armed and its length is non-zero, the request output is high and the memory address output equals the live set's address.
- R5: Each acknowledged request adds 4 to the live address and subtracts 4 from the live length on the next clock edge.
- R6: An acknowledge that brings the length from 4 to 0 also clears command bit 0 and sets the completion flag (control bit 3). The request falls on the same edge.
- R7: A live set that is armed with length 0 completes on the next edge without raising a request.
- R8: Writing a 1 to control bit 0 swaps the live set only when the idle set is armed and the live set is not armed. Otherwise the live set is unchanged and the error flag (control bit 4) is set. Control bit 2 reads the number of the live set, and bit 0 always reads 0.
- R9: Control bit 1 is the interrupt enable. Writing a 1 to bit 3 or to bit 4 clears that flag. The interrupt output equals completion flag AND enable.
- R10: While the live set is armed, writes to its descriptor fields are dropped. Writes to the idle set always take effect.
- R11: If a completion and a write clearing the completion flag land on the same edge, the flag ends up set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | 13 | Register byte offset |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Register read data (combinational) |
| mem_req | output | 7 | Per-channel word request |
| mem_addr | output | 224 | Per-channel word address, channel c in bits [32c+31:32c] |
| mem_ack | input | 7 | Per-channel acknowledge, one word per cycle |
| irq | output | 7 | Per-channel completion interrupt |

## Verification
The bench writes a distinct pattern into every field of every set of every channel, then reads all of them back. This tells a decode that aliases a channel, a set or a field apart from one that is correct. It then runs a transfer on each channel, with transfer lengths of one to seven words and acknowledge gaps of one to three cycles. This separates a counter that steps on every acknowledge from one that steps on every cycle or stops one word early. The swap handshake is tried in each of its states: idle set unarmed, live set still busy, and a legal swap. It is also tried with an armed set of zero length, and with a completion colliding with a flag clear. Each case exposes a different wrong priority.

// File: rtl/dbd_pkg.sv
package dbd_pkg;

    typedef enum logic [1:0] {
        FLD_ADDR = 2'd0,
        FLD_LEN  = 2'd1,
        FLD_CMD  = 2'd2,
        FLD_NONE = 2'd3
    } fld_e;

    localparam int CB_FLIP = 0;
    localparam int CB_IEN  = 1;
    localparam int CB_ACT  = 2;
    localparam int CB_DONE = 3;
    localparam int CB_ERR  = 4;

endpackage

// File: rtl/dbd_decode.sv
module dbd_decode
    import dbd_pkg::*;
#(
    parameter int NUM_CH = 7,
    parameter int RA_W   = 13,
    parameter int CH_W   = 3
) (
    input  logic [RA_W-1:0] addr,
    output logic            is_ctl,
    output logic            is_desc,
    output logic [CH_W-1:0] ch,
    output logic            set,
    output fld_e            fld
);
    localparam logic [RA_W-1:0] CTL_BASE  = RA_W'('hC00);
    localparam logic [RA_W-1:0] CTL_SPAN  = RA_W'(NUM_CH * 16);
    localparam logic [RA_W-1:0] DESC_BASE = RA_W'('h1000);
    localparam logic [RA_W-1:0] DESC_SPAN = RA_W'(NUM_CH * 32);

    logic [RA_W-1:0] off_c;
    logic [RA_W-1:0] off_d;
    logic            in_ctl;
    logic            in_desc;

    always_comb begin
        off_c   = addr - CTL_BASE;
        off_d   = addr - DESC_BASE;
        in_ctl  = (addr >= CTL_BASE) && (off_c < CTL_SPAN) && (off_c[3:0] == 4'h0);
        in_desc = (addr >= DESC_BASE) && (off_d < DESC_SPAN);
        case (off_d[3:0])
            4'h0:    fld = FLD_ADDR;
            4'h4:    fld = FLD_LEN;
            4'h8:    fld = FLD_CMD;
            default: fld = FLD_NONE;
        endcase
        is_ctl  = in_ctl;
        is_desc = in_desc && (fld != FLD_NONE);
        set     = off_d[4];
        ch      = in_ctl ? off_c[CH_W+3:4] : off_d[CH_W+4:5];
    end
endmodule

// File: rtl/dbd_chan.sv
module dbd_chan
    import dbd_pkg::*;
#(
    parameter int AW = 32,
    parameter int LW = 16
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          we_ctl,
    input  logic          we_desc,
    input  logic          sel_ctl,
    input  logic          sel_set,
    input  fld_e          sel_fld,
    input  logic [31:0]   wdata,
    output logic [31:0]   rdata,
    output logic          mem_req,
    output logic [AW-1:0] mem_addr,
    input  logic          mem_ack,
    output logic          irq
);
    typedef struct packed {
        logic [1:0][AW-1:0] addr;
        logic [1:0][LW-1:0] len;
        logic [1:0][31:0]   cmd;
        logic               act;
        logic               ien;
        logic               done;
        logic               err;
    } st_t;

    st_t  st_d, st_q;
    logic busy;

    always_comb begin
        st_d = st_q;
        busy = st_q.cmd[st_q.act][0];

        if (we_ctl) begin
            st_d.ien = wdata[CB_IEN];
            if (wdata[CB_DONE]) st_d.done = 1'b0;
            if (wdata[CB_ERR])  st_d.err  = 1'b0;
            if (wdata[CB_FLIP]) begin
                if (st_q.cmd[~st_q.act][0] && !busy) st_d.act = ~st_q.act;
                else                                  st_d.err = 1'b1;
            end
        end

        if (we_desc && !(sel_set == st_q.act && busy)) begin
            case (sel_fld)
                FLD_ADDR: st_d.addr[sel_set] = wdata[AW-1:0];
                FLD_LEN:  st_d.len[sel_set]  = {wdata[LW-1:2], 2'b00};
                FLD_CMD:  st_d.cmd[sel_set]  = wdata;
                default:  ;
            endcase
        end

        // completion is evaluated last so it wins over a same-cycle flag clear
        if (busy) begin
            if (st_q.len[st_q.act] == '0) begin
                st_d.cmd[st_q.act][0] = 1'b0;
                st_d.done             = 1'b1;
            end else if (mem_ack) begin
                st_d.addr[st_q.act] = st_q.addr[st_q.act] + AW'(4);
                st_d.len[st_q.act]  = st_q.len[st_q.act] - LW'(4);
                if (st_q.len[st_q.act] == LW'(4)) begin
                    st_d.cmd[st_q.act][0] = 1'b0;
                    st_d.done             = 1'b1;
                end
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    always_comb begin
        mem_req  = st_q.cmd[st_q.act][0] && (st_q.len[st_q.act] != '0);
        mem_addr = st_q.addr[st_q.act];
        irq      = st_q.done && st_q.ien;
        rdata    = '0;
        if (sel_ctl) begin
            rdata[CB_IEN]  = st_q.ien;
            rdata[CB_ACT]  = st_q.act;
            rdata[CB_DONE] = st_q.done;
            rdata[CB_ERR]  = st_q.err;
        end else begin
            case (sel_fld)
                FLD_ADDR: rdata = 32'(st_q.addr[sel_set]);
                FLD_LEN:  rdata = 32'(st_q.len[sel_set]);
                FLD_CMD:  rdata = st_q.cmd[sel_set];
                default:  rdata = '0;
            endcase
        end
    end
endmodule

// File: rtl/dbd_dma_bank.sv
module dbd_dma_bank
    import dbd_pkg::*;
#(
    parameter int NUM_CH = 7,
    parameter int AW     = 32,
    parameter int LW     = 16,
    parameter int RA_W   = 13
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 reg_wr,
    input  logic [RA_W-1:0]      reg_addr,
    input  logic [31:0]          reg_wdata,
    output logic [31:0]          reg_rdata,
    output logic [NUM_CH-1:0]    mem_req,
    output logic [NUM_CH*AW-1:0] mem_addr,
    input  logic [NUM_CH-1:0]    mem_ack,
    output logic [NUM_CH-1:0]    irq
);
    localparam int CH_W = (NUM_CH > 1) ? $clog2(NUM_CH) : 1;

    logic            dec_ctl;
    logic            dec_desc;
    logic [CH_W-1:0] dec_ch;
    logic            dec_set;
    fld_e            dec_fld;

    logic [NUM_CH-1:0]       ch_sel;
    logic [NUM_CH-1:0][31:0] ch_rdata;

    dbd_decode #(.NUM_CH(NUM_CH), .RA_W(RA_W), .CH_W(CH_W)) i_decode (
        .addr    (reg_addr),
        .is_ctl  (dec_ctl),
        .is_desc (dec_desc),
        .ch      (dec_ch),
        .set     (dec_set),
        .fld     (dec_fld)
    );

    for (genvar c = 0; c < NUM_CH; c++) begin : g_ch
        assign ch_sel[c] = (dec_ctl || dec_desc) && (dec_ch == CH_W'(c));

        dbd_chan #(.AW(AW), .LW(LW)) i_chan (
            .clk      (clk),
            .rst_n    (rst_n),
            .we_ctl   (reg_wr && dec_ctl && ch_sel[c]),
            .we_desc  (reg_wr && dec_desc && ch_sel[c]),
            .sel_ctl  (dec_ctl),
            .sel_set  (dec_set),
            .sel_fld  (dec_fld),
            .wdata    (reg_wdata),
            .rdata    (ch_rdata[c]),
            .mem_req  (mem_req[c]),
            .mem_addr (mem_addr[c*AW +: AW]),
            .mem_ack  (mem_ack[c]),
            .irq      (irq[c])
        );
    end

    always_comb begin
        reg_rdata = '0;
        for (int c = 0; c < NUM_CH; c++) begin
            if (ch_sel[c]) reg_rdata = reg_rdata | ch_rdata[c];
        end
    end
endmodule

// File: rtl/dbd_check.sv
module dbd_check #(
    parameter int NUM_CH = 7,
    parameter int AW     = 32
) (
    input logic                 clk,
    input logic                 rst_n,
    input logic [NUM_CH-1:0]    mem_req,
    input logic [NUM_CH*AW-1:0] mem_addr,
    input logic [NUM_CH-1:0]    mem_ack,
    input logic [NUM_CH-1:0]    irq
);
    AST_RESET_IDLE: assert property (@(posedge clk)
        !rst_n |=> (mem_req == '0) && (irq == '0)); // R2

    for (genvar c = 0; c < NUM_CH; c++) begin : g_chk
        AST_ADDR_STEP: assert property (@(posedge clk) disable iff (!rst_n)
            mem_req[c] && mem_ack[c] |=> mem_addr[c*AW +: AW] == $past(mem_addr[c*AW +: AW]) + AW'(4)); // R5

        AST_ADDR_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
            mem_req[c] && !mem_ack[c] |=> $stable(mem_addr[c*AW +: AW]) && mem_req[c]); // R10

        AST_REQ_DROP: assert property (@(posedge clk) disable iff (!rst_n)
            $fell(mem_req[c]) |-> $past(mem_ack[c])); // R6
    end
endmodule

bind dbd_dma_bank dbd_check #(.NUM_CH(NUM_CH), .AW(AW)) i_dbd_check (
    .clk      (clk),
    .rst_n    (rst_n),
    .mem_req  (mem_req),
    .mem_addr (mem_addr),
    .mem_ack  (mem_ack),
    .irq      (irq)
);

// File: tb/test_dbd_dma_bank.sv
module test_dbd_dma_bank;
    localparam int NCH = 7;

    logic           clk = 1'b0;
    logic           rst_n = 1'b0;
    logic           reg_wr = 1'b0;
    logic [12:0]    reg_addr = '0;
    logic [31:0]    reg_wdata = '0;
    logic [31:0]    reg_rdata;
    logic [NCH-1:0] mem_req;
    logic [NCH*32-1:0] mem_addr;
    logic [NCH-1:0] mem_ack = '0;
    logic [NCH-1:0] irq;

    int n_tot = 0;
    int n_bad = 0;

    always #2 clk = ~clk;

    dbd_dma_bank i_dbd_dma_bank (
        .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_addr(reg_addr),
        .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .mem_req(mem_req),
        .mem_addr(mem_addr), .mem_ack(mem_ack), .irq(irq)
    );

    function automatic logic [12:0] ctl_a(int ch);
        return 13'(12'hC00 + ch * 16);
    endfunction

    function automatic logic [12:0] dsc_a(int ch, int s, int f);
        return 13'(13'h1000 + ch * 32 + s * 16 + f * 4);
    endfunction

    task automatic chk(string tag, logic [31:0] act, logic [31:0] exp);
        n_tot++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic wr(logic [12:0] a, logic [31:0] d);
        @(negedge clk);
        reg_addr = a; reg_wdata = d; reg_wr = 1'b1;
        @(negedge clk);
        reg_wr = 1'b0;
    endtask

    task automatic rd(logic [12:0] a, output logic [31:0] d);
        reg_addr = a;
        #1;
        d = reg_rdata;
    endtask

    task automatic xfer(int ch, logic [31:0] a0, int words, int gap);
        logic [31:0] a = a0;
        int k = 0;
        int w = 0;
        bit fresh = 1'b1;
        while (w < words) begin
            @(negedge clk);
            if (fresh) begin
                chk("R4 req", 32'(mem_req[ch]), 32'd1);
                chk("R5 addr", mem_addr[ch*32 +: 32], a);
                fresh = 1'b0;
            end
            mem_ack[ch] = ((k % gap) == gap - 1);
            k++;
            @(posedge clk);
            if (mem_ack[ch]) begin
                a = a + 4; w++; fresh = 1'b1;
            end
        end
        @(negedge clk);
        mem_ack[ch] = 1'b0;
        chk("R6 req low", 32'(mem_req[ch]), 32'd0);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        n_bad++;
        $display("FAIL watchdog actual=timeout expected=finish");
        $display("test done: total=%0d bad=%0d", n_tot, n_bad);
        $finish;
    end

    initial begin
        logic [31:0] v;
        repeat (3) @(negedge clk);
        // R2 reset state
        for (int c = 0; c < NCH; c++) begin
            rd(ctl_a(c), v); chk("R2 ctl", v, 32'h0);
            for (int s = 0; s < 2; s++)
                for (int f = 0; f < 3; f++) begin
                    rd(dsc_a(c, s, f), v); chk("R2 desc", v, 32'h0);
                end
        end
        chk("R2 req", 32'(mem_req), 32'h0);
        chk("R2 irq", 32'(irq), 32'h0);
        rst_n = 1'b1;

        // R1 / R3 decode sweep
        for (int c = 0; c < NCH; c++)
            for (int s = 0; s < 2; s++) begin
                wr(dsc_a(c, s, 0), 32'hA000_0000 | (c << 8) | (s << 4));
                wr(dsc_a(c, s, 1), 32'hFFFF_0103 + c * 16 + s * 4);
                wr(dsc_a(c, s, 2), 32'h5A00_0002 | (c << 8) | (s << 4));
            end
        for (int c = 0; c < NCH; c++)
            for (int s = 0; s < 2; s++) begin
                rd(dsc_a(c, s, 0), v); chk("R1 addr", v, 32'hA000_0000 | (c << 8) | (s << 4));
                rd(dsc_a(c, s, 1), v); chk("R3 len", v, (32'h0103 + c * 16 + s * 4) & 32'hFFFC);
                rd(dsc_a(c, s, 2), v); chk("R1 cmd", v, 32'h5A00_0002 | (c << 8) | (s << 4));
            end
        rd(13'h100C, v); chk("R1 hole", v, 0);
        rd(13'h0C08, v); chk("R1 hole", v, 0);
        rd(13'h0C70, v); chk("R1 beyond ctl", v, 0);
        rd(13'h10E0, v); chk("R1 beyond desc", v, 0);
        chk("R4 idle req", 32'(mem_req), 32'h0);

        // R4/R5/R6/R9 transfer sweep
        for (int c = 0; c < NCH; c++) begin
            logic [31:0] a0 = 32'h1000_0000 + c * 32'h100;
            wr(dsc_a(c, 0, 0), a0);
            wr(dsc_a(c, 0, 1), (c + 1) * 4);
            wr(dsc_a(c, 0, 2), 32'h1);
            xfer(c, a0, c + 1, c % 3 + 1);
            rd(dsc_a(c, 0, 1), v); chk("R6 len zero", v, 0);
            rd(dsc_a(c, 0, 2), v); chk("R6 disarm", v, 0);
            rd(dsc_a(c, 0, 0), v); chk("R5 final addr", v, a0 + 4 * (c + 1));
            rd(ctl_a(c), v); chk("R6 done", v, 32'h8);
            chk("R9 irq off", 32'(irq[c]), 0);
            wr(ctl_a(c), 32'h2);
            chk("R9 irq on", 32'(irq[c]), 1);
            wr(ctl_a(c), 32'hA);
            chk("R9 irq cleared", 32'(irq[c]), 0);
            rd(ctl_a(c), v); chk("R9 ctl", v, 32'h2);
            wr(ctl_a(c), 32'h0);
        end

        // R8 / R10 / R7 swap handshake on channel 1
        wr(ctl_a(1), 32'h1);
        rd(ctl_a(1), v); chk("R8 refuse unarmed", v, 32'h10);
        wr(ctl_a(1), 32'h10);
        rd(ctl_a(1), v); chk("R9 err clear", v, 32'h0);
        wr(dsc_a(1, 1, 0), 32'h2000_0000);
        wr(dsc_a(1, 1, 1), 32'd12);
        wr(dsc_a(1, 1, 2), 32'h1);
        wr(ctl_a(1), 32'h1);
        rd(ctl_a(1), v); chk("R8 swap", v, 32'h4);
        chk("R4 req", 32'(mem_req[1]), 1);
        chk("R4 addr", mem_addr[32 +: 32], 32'h2000_0000);
        wr(dsc_a(1, 1, 0), 32'hDEAD_0000);
        rd(dsc_a(1, 1, 0), v); chk("R10 live ignored", v, 32'h2000_0000);
        wr(dsc_a(1, 0, 0), 32'h3000_0000);
        wr(dsc_a(1, 0, 1), 32'h0);
        wr(dsc_a(1, 0, 2), 32'h1);
        rd(dsc_a(1, 0, 0), v); chk("R10 idle written", v, 32'h3000_0000);
        wr(ctl_a(1), 32'h1);
        rd(ctl_a(1), v); chk("R8 refuse busy", v, 32'h14);
        wr(ctl_a(1), 32'h10);
        xfer(1, 32'h2000_0000, 3, 2);
        rd(ctl_a(1), v); chk("R6 done set1", v, 32'hC);
        wr(ctl_a(1), 32'h9);
        chk("R7 no req", 32'(mem_req[1]), 0);
        @(negedge clk);
        chk("R7 no req", 32'(mem_req[1]), 0);
        rd(ctl_a(1), v); chk("R7 done", v, 32'h8);
        rd(dsc_a(1, 0, 2), v); chk("R7 disarm", v, 32'h0);

        // R11 completion vs clear on channel 2
        wr(dsc_a(2, 0, 0), 32'h4000_0000);
        wr(dsc_a(2, 0, 1), 32'd4);
        wr(dsc_a(2, 0, 2), 32'h1);
        @(negedge clk);
        reg_addr = ctl_a(2); reg_wdata = 32'h8; reg_wr = 1'b1; mem_ack[2] = 1'b1;
        @(negedge clk);
        reg_wr = 1'b0; mem_ack[2] = 1'b0;
        rd(ctl_a(2), v); chk("R11 done wins", v, 32'h8);
        chk("R11 req low", 32'(mem_req[2]), 0);

        $display("test done: total=%0d bad=%0d", n_tot, n_bad);
        $finish;
    end
endmodule